// File: doc/BRIEF.md
# Parity-Protected RAM Cycle Controller

This block runs the read and write cycles of a 32-bit RAM array that keeps one parity bit beside each data byte. A requester hands it a request on a valid/ready channel: the byte address, a write flag, a 16-bit-access flag, a cache-fill flag and the write data. For a write the controller captures the address and data, generates odd parity for every byte and stores data and parity in a single RAM cycle. For a read it captures the address, reads the word and its parity bits and checks them. It then places the word on a valid/ready response channel together with an error flag.

A cache-fill request returns four long words of one aligned 16-byte line. The line is walked upward from the requested word and wraps to the start of the line. Requesters that are 16 bits wide are served by a fold path. On a read it moves the addressed halfword into the low half of the response. On a write it copies the low input halfword onto the addressed lane and writes only those two bytes. A small control register enables parity checking and the parity interrupt, and holds a sticky parity-error flag that drives the interrupt. The RAM itself is outside the block and has a one-cycle read latency.

Back-pressure rules: a request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle. The controller holds `rsp_valid`, `rsp_rdata` and `rsp_perr` unchanged until `rsp_ready` is seen high on a clock edge. Writes produce no response.

Top module: `pram_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0, `irq` is 0 and `ctl_rdata` reads 3'b001 (bit 0 parity check enable = 1, bit 1 interrupt enable = 0, bit 2 parity-error flag = 0).
- R2: A 32-bit write issues one RAM write at word address `req_addr[AW-1:2]` with `ram_wmask` = 4'b1111, the request data, and, for each byte i, `ram_wpar[i]` chosen so that byte i together with its parity bit holds an odd number of ones.
- R3: A 32-bit read returns exactly one response whose `rsp_rdata` equals the stored word, with `rsp_perr` = 0 when every stored parity bit is correct.
- R4: With checking enabled, a read whose checked bytes include a byte with wrong stored parity returns `rsp_perr` = 1, still delivers the stored data, and sets the parity-error flag (`ctl_rdata[2]`).
- R5: With checking disabled (`ctl_rdata[0]` = 0), reads return `rsp_perr` = 0 and leave the parity-error flag unchanged, while writes still store correct odd parity.
- R6: A cache-fill read (`req_quad` = 1, `req_write` = 0) returns four responses for words w, w+1, w+2, w+3 of the aligned four-word line, each index taken modulo 4 within the line, where w is the requested word.
- R7: A 16-bit read (`req_half` = 1) returns the halfword chosen by `req_addr[1]` (1 = bits 31:16, 0 = bits 15:0) in `rsp_rdata[15:0]` with `rsp_rdata[31:16]` = 0, and checks parity only on the two bytes of that halfword.
- R8: A 16-bit write places `req_wdata[15:0]` on the lane chosen by `req_addr[1]`, with `ram_wmask` = 4'b1100 for the upper lane and 4'b0011 for the lower lane, so the other two bytes and their parity stay unchanged.
- R9: The parity-error flag is sticky. Writing the control register with bit 2 = 1 clears it, and a new error in the same cycle wins. `irq` = flag AND interrupt enable.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, the response fields hold. `req_ready` is 0 from acceptance until the cycle finishes, and no RAM access occurs while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_half | input | 1 | 16-bit access |
| req_quad | input | 1 | Cache-fill read of four words |
| req_addr | input | AW | Byte address |
| req_wdata | input | 32 | Write data (low half used for 16-bit writes) |
| rsp_valid | output | 1 | Read response available |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_rdata | output | 32 | Read data, folded for 16-bit reads |
| rsp_perr | output | 1 | Parity error on this beat |
| ram_en | output | 1 | RAM access this cycle |
| ram_we | output | 1 | RAM access is a write |
| ram_addr | output | AW-2 | RAM word address |
| ram_wmask | output | 4 | Byte write enables |
| ram_wdata | output | 32 | RAM write data |
| ram_wpar | output | 4 | RAM write parity, one bit per byte |
| ram_rdata | input | 32 | RAM read data, valid the cycle after a read access |
| ram_rpar | input | 4 | RAM read parity, aligned with `ram_rdata` |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | Control write: bit 0 check enable, bit 1 interrupt enable, bit 2 write-1 clears the error flag |
| ctl_rdata | output | 3 | Control read: check enable, interrupt enable, error flag |
| irq | output | 1 | Parity interrupt |

## Verification
The bench builds the controller with AW = 8 and LINE_WORDS = 4. This gives a 64-word RAM that a directed fill can cover completely, so every random read has a known stored word. The small space makes random requests hit the same lines and halfwords often. Half writes, corrupted parity bits and cache-fill wraps therefore land on each other's words. With four words per line, a start at the last word of a line reaches the wrap on the second beat.

// File: rtl/pram_pkg.sv
package pram_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned BYTES_N = DATA_W / 8;
  localparam int unsigned HALF_W  = DATA_W / 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_READ,
    ST_CAPTURE,
    ST_RESPOND
  } seq_state_t;

  typedef struct packed {
    logic irq_en;
    logic chk_en;
  } ctl_cfg_t;
endpackage

// File: rtl/pram_parity.sv
module pram_parity #(
  parameter int unsigned NBYTES = 4
) (
  input  logic [NBYTES*8-1:0] data,
  output logic [NBYTES-1:0]   par
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign par[b] = ~(^data[b*8 +: 8]);
  end
endmodule

// File: rtl/pram_fold.sv
module pram_fold
  import pram_pkg::*;
(
  input  logic              half,
  input  logic              hi,
  input  logic [DATA_W-1:0] wr_in,
  input  logic [DATA_W-1:0] rd_in,
  output logic [DATA_W-1:0] wr_lane,
  output logic [BYTES_N-1:0] lane_mask,
  output logic [DATA_W-1:0] rd_out
);
  localparam int unsigned HB = BYTES_N / 2;

  always_comb begin
    if (half) begin
      wr_lane   = {wr_in[HALF_W-1:0], wr_in[HALF_W-1:0]};
      lane_mask = hi ? {{HB{1'b1}}, {HB{1'b0}}} : {{HB{1'b0}}, {HB{1'b1}}};
      rd_out    = {{HALF_W{1'b0}}, (hi ? rd_in[DATA_W-1:HALF_W] : rd_in[HALF_W-1:0])};
    end else begin
      wr_lane   = wr_in;
      lane_mask = '1;
      rd_out    = rd_in;
    end
  end
endmodule

// File: rtl/pram_ctl.sv
module pram_ctl
  import pram_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [2:0] wdata,
  input  logic       err_set,
  output ctl_cfg_t   cfg,
  output logic       err_flag,
  output logic       irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg.chk_en <= 1'b1;
      cfg.irq_en <= 1'b0;
      err_flag   <= 1'b0;
    end else begin
      if (wr) begin
        cfg.chk_en <= wdata[0];
        cfg.irq_en <= wdata[1];
      end
      if (err_set)
        err_flag <= 1'b1;
      else if (wr && wdata[2])
        err_flag <= 1'b0;
    end
  end

  assign irq = err_flag & cfg.irq_en;
endmodule

// File: rtl/pram_ctrl.sv
module pram_ctrl
  import pram_pkg::*;
#(
  parameter int unsigned AW         = 16,
  parameter int unsigned LINE_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_half,
  input  logic              req_quad,
  input  logic [AW-1:0]     req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_perr,
  output logic              ram_en,
  output logic              ram_we,
  output logic [AW-3:0]     ram_addr,
  output logic [3:0]        ram_wmask,
  output logic [31:0]       ram_wdata,
  output logic [3:0]        ram_wpar,
  input  logic [31:0]       ram_rdata,
  input  logic [3:0]        ram_rpar,
  input  logic              ctl_wr,
  input  logic [2:0]        ctl_wdata,
  output logic [2:0]        ctl_rdata,
  output logic              irq
);
  localparam int unsigned WAW = AW - 2;
  localparam int unsigned LWB = $clog2(LINE_WORDS);
  localparam logic [LWB-1:0] LAST_BEAT = LWB'(LINE_WORDS - 1);

  seq_state_t        state;
  logic [WAW-1:0]    a_word;
  logic              a_hi, is_half, is_quad;
  logic [DATA_W-1:0] wdat_q, rsp_data_q;
  logic              rsp_perr_q;
  logic [LWB-1:0]    beat;

  logic [DATA_W-1:0]  wr_lane, rd_folded;
  logic [BYTES_N-1:0] lane_mask, gen_par, chk_par, bad_bytes;
  logic               cap, mismatch, perr_hit, err_flag;
  ctl_cfg_t           cfg;

  pram_fold u_fold (
    .half(is_half), .hi(a_hi), .wr_in(wdat_q), .rd_in(ram_rdata),
    .wr_lane(wr_lane), .lane_mask(lane_mask), .rd_out(rd_folded)
  );

  pram_parity #(.NBYTES(BYTES_N)) u_gen (.data(wr_lane),   .par(gen_par));
  pram_parity #(.NBYTES(BYTES_N)) u_chk (.data(ram_rdata), .par(chk_par));

  // Bytes whose stored parity disagrees, limited to the lanes this access reads.
  assign bad_bytes = (chk_par ^ ram_rpar) & lane_mask;
  assign cap       = (state == ST_CAPTURE);
  assign mismatch  = |bad_bytes;
  assign perr_hit  = cap & mismatch & cfg.chk_en;

  pram_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata),
    .err_set(perr_hit), .cfg(cfg), .err_flag(err_flag), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      a_word     <= '0;
      a_hi       <= 1'b0;
      is_half    <= 1'b0;
      is_quad    <= 1'b0;
      wdat_q     <= '0;
      beat       <= '0;
      rsp_data_q <= '0;
      rsp_perr_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          a_word  <= req_addr[AW-1:2];
          a_hi    <= req_addr[1];
          is_quad <= req_quad & ~req_write;
          is_half <= req_half & (req_write | ~req_quad);
          wdat_q  <= req_wdata;
          beat    <= '0;
          state   <= req_write ? ST_WRITE : ST_READ;
        end
        ST_WRITE:   state <= ST_IDLE;
        ST_READ:    state <= ST_CAPTURE;
        ST_CAPTURE: begin
          rsp_data_q <= rd_folded;
          rsp_perr_q <= mismatch & cfg.chk_en;
          state      <= ST_RESPOND;
        end
        ST_RESPOND: if (rsp_ready) begin
          if (is_quad && beat != LAST_BEAT) begin
            beat              <= beat + 1'b1;
            a_word[LWB-1:0]   <= a_word[LWB-1:0] + 1'b1;
            state             <= ST_READ;
          end else begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_RESPOND);
  assign rsp_rdata = rsp_data_q;
  assign rsp_perr  = rsp_perr_q;

  assign ram_en    = (state == ST_WRITE) || (state == ST_READ);
  assign ram_we    = (state == ST_WRITE);
  assign ram_addr  = a_word;
  assign ram_wmask = lane_mask;
  assign ram_wdata = wr_lane;
  assign ram_wpar  = gen_par;
  assign ctl_rdata = {err_flag, cfg.irq_en, cfg.chk_en};
endmodule

// File: rtl/pram_ctrl_chk.sv
module pram_ctrl_chk #(
  parameter int unsigned AW = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_rdata,
  input logic        rsp_perr,
  input logic        ram_en,
  input logic        ram_we,
  input logic [3:0]  ram_wmask,
  input logic [31:0] ram_wdata,
  input logic [3:0]  ram_wpar,
  input logic [2:0]  ctl_rdata,
  input logic        irq
);
  logic [3:0] odd_ref;
  for (genvar b = 0; b < 4; b++) begin : g_ref
    assign odd_ref[b] = ~(^ram_wdata[b*8 +: 8]);
  end

  a_r2_write_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && ram_we) |-> (((ram_wpar ^ odd_ref) & ram_wmask) == 4'b0000));

  a_r8_lane_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && ram_we) |-> (ram_wmask == 4'b1111 || ram_wmask == 4'b1100 || ram_wmask == 4'b0011));

  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_perr)));

  a_r10_busy_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !ram_en);

  a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ctl_rdata[2] && ctl_rdata[1]));
endmodule

bind pram_ctrl pram_ctrl_chk #(.AW(AW)) u_pram_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_perr(rsp_perr),
  .ram_en(ram_en), .ram_we(ram_we), .ram_wmask(ram_wmask), .ram_wdata(ram_wdata),
  .ram_wpar(ram_wpar), .ctl_rdata(ctl_rdata), .irq(irq)
);

// File: tb/sim_pram_ctrl.sv
module sim_pram_ctrl;
  localparam int unsigned AW = 8;
  localparam int unsigned NW = 1 << (AW - 2);
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_half = 0, req_quad = 0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_ready = 0, ctl_wr = 0;
  logic [2:0] ctl_wdata = '0;
  logic req_ready, rsp_valid, rsp_perr, ram_en, ram_we, irq;
  logic [31:0] rsp_rdata, ram_wdata, ram_rdata;
  logic [AW-3:0] ram_addr;
  logic [3:0] ram_wmask, ram_wpar, ram_rpar;
  logic [2:0] ctl_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  pram_ctrl #(.AW(AW), .LINE_WORDS(4)) u0 (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_half, .req_quad,
    .req_addr, .req_wdata, .rsp_valid, .rsp_ready, .rsp_rdata, .rsp_perr,
    .ram_en, .ram_we, .ram_addr, .ram_wmask, .ram_wdata, .ram_wpar,
    .ram_rdata, .ram_rpar, .ctl_wr, .ctl_wdata, .ctl_rdata, .irq
  );

  // RAM model with a parity-corruption port driven by the stimulus.
  logic [31:0] mem [NW];
  logic [3:0]  par [NW];
  logic        flip_req = 0;
  logic [AW-3:0] flip_word = '0;
  logic [1:0]  flip_byte = '0;

  always @(posedge clk) begin
    if (flip_req) par[flip_word][flip_byte] <= ~par[flip_word][flip_byte];
    if (ram_en) begin
      if (ram_we) begin
        for (int b = 0; b < 4; b++)
          if (ram_wmask[b]) begin
            mem[ram_addr][b*8 +: 8] <= ram_wdata[b*8 +: 8];
            par[ram_addr][b]        <= ram_wpar[b];
          end
      end else begin
        ram_rdata <= mem[ram_addr];
        ram_rpar  <= par[ram_addr];
      end
    end
  end

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] shadow [NW];
  logic exp_pe = 1, exp_ie = 0, exp_flag = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] odd4(input logic [31:0] d);
    for (int b = 0; b < 4; b++) odd4[b] = ~(^d[b*8 +: 8]);
  endfunction

  function automatic logic [3:0] lanes(input bit half, input bit hi);
    return !half ? 4'b1111 : (hi ? 4'b1100 : 4'b0011);
  endfunction

  function automatic logic [31:0] fold_rd(input logic [31:0] d, input bit half, input bit hi);
    return !half ? d : {16'h0, hi ? d[31:16] : d[15:0]};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic ctl_write(input logic [2:0] v);
    @(negedge clk);
    ctl_wr = 1; ctl_wdata = v;
    @(negedge clk);
    ctl_wr = 0;
    exp_pe = v[0]; exp_ie = v[1];
    if (v[2]) exp_flag = 0;
  endtask

  task automatic flip(input int w, input int b);
    @(negedge clk);
    flip_req = 1; flip_word = AW'(w) >> 0; flip_byte = 2'(b);
    @(negedge clk);
    flip_req = 0;
  endtask

  task automatic issue(input bit wr, input bit half, input bit quad, input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_half = half; req_quad = quad;
    req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    check(!req_ready, "R10 busy after accept", 32'(req_ready), 0);
  endtask

  task automatic do_write(input bit half, input logic [AW-1:0] a, input logic [31:0] d);
    int w = int'(a >> 2);
    logic [3:0] m = lanes(half, a[1]);
    logic [31:0] lane = half ? {d[15:0], d[15:0]} : d;
    issue(1, half, 0, a, d);
    while (!req_ready) @(negedge clk);
    for (int b = 0; b < 4; b++) if (m[b]) shadow[w][b*8 +: 8] = lane[b*8 +: 8];
    check(mem[w] == shadow[w], half ? "R8 half write data" : "R2 write data", mem[w], shadow[w]);
    check((par[w] & m) == (odd4(shadow[w]) & m), exp_pe ? "R2 stored parity" : "R5 parity stored while off",
          32'(par[w]), 32'(odd4(shadow[w])));
  endtask

  task automatic take_beat(input int w, input bit half, input bit hi, input string tag);
    logic [31:0] first_d;
    logic first_p, exp_err;
    int stall = $urandom_range(0, 2);
    while (!rsp_valid) @(negedge clk);
    exp_err = exp_pe && (((odd4(mem[w]) ^ par[w]) & lanes(half, hi)) != 0);
    if (exp_err) exp_flag = 1;
    first_d = rsp_rdata; first_p = rsp_perr;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check(rsp_valid && rsp_rdata == first_d && rsp_perr == first_p, "R10 hold under stall", rsp_rdata, first_d);
    end
    check(rsp_rdata == fold_rd(shadow[w], half, hi), tag, rsp_rdata, fold_rd(shadow[w], half, hi));
    check(rsp_perr == exp_err, exp_pe ? "R4 perr flag" : "R5 no perr when off", 32'(rsp_perr), 32'(exp_err));
    check(ctl_rdata[2] == exp_flag, "R9 sticky flag", 32'(ctl_rdata[2]), 32'(exp_flag));
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
  endtask

  task automatic do_read(input bit half, input bit quad, input logic [AW-1:0] a);
    int w = int'(a >> 2);
    issue(0, half, quad, a, 0);
    if (!quad) begin
      take_beat(w, half, a[1], half ? "R7 half read" : "R3 read data");
    end else begin
      for (int k = 0; k < 4; k++)
        take_beat((w & ~3) | ((w + k) & 3), 0, 0, "R6 quad beat order");
    end
    @(negedge clk);
    check(!rsp_valid && req_ready, "R3 single response", 32'(rsp_valid), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(req_ready == 1 && rsp_valid == 0 && irq == 0, "R1 reset outputs",
          {29'd0, req_ready, rsp_valid, irq}, 32'b100);
    check(ctl_rdata == 3'b001, "R1 reset control", 32'(ctl_rdata), 1);

    for (int w = 0; w < NW; w++) do_write(0, AW'(w * 4), $urandom);
    do_read(0, 0, 8'h10);

    // Parity error with interrupt enabled.
    ctl_write(3'b011);
    flip(5, 2);
    do_read(0, 0, 8'h14);
    check(irq == 1, "R9 irq raised", 32'(irq), 1);
    ctl_write(3'b111);
    check(ctl_rdata[2] == 0 && irq == 0, "R9 write-1 clears", 32'(ctl_rdata), 3'b011);

    // Checking off: no error, flag untouched; writes keep good parity.
    ctl_write(3'b010);
    do_read(0, 0, 8'h14);
    check(ctl_rdata[2] == 0, "R5 flag unchanged", 32'(ctl_rdata[2]), 0);
    do_write(0, 8'h14, 32'hA5A5_0F0F);
    ctl_write(3'b011);

    // Halfword lanes and per-half checking.
    do_write(1, 8'h26, 32'h1234_BEEF);
    do_write(1, 8'h24, 32'hFFFF_0001);
    flip(9, 0);
    do_read(1, 0, 8'h26);
    do_read(1, 0, 8'h24);
    ctl_write(3'b111);

    // Cache fill starting at the last word of a line.
    do_read(0, 1, 8'h1C);
    do_read(0, 1, 8'h18);

    for (int i = 0; i < 300; i++) begin
      int op = $urandom_range(0, 9);
      logic [AW-1:0] a = AW'($urandom) & ~AW'(1);
      if (op < 3) do_write($urandom_range(0, 1), a, $urandom);
      else if (op < 6) do_read($urandom_range(0, 1), 0, a);
      else if (op < 7) do_read(0, 1, a);
      else if (op < 8) flip($urandom_range(0, NW - 1), $urandom_range(0, 3));
      else ctl_write(3'($urandom_range(0, 7)));
      check(irq == (exp_flag && exp_ie), "R9 irq gating", 32'(irq), 32'(exp_flag && exp_ie));
    end
    finish_run();
  end
endmodule